// File: doc/BRIEF.md
# Masked Tile Element-Status Classifier

This block sits beside the element sequencer of a vector tile load/store unit. On each beat it receives one group of consecutive element indices (a base index plus one lane per element), the operation's start index and vector length, the mask-enable bit, the mask bits of the group, and the two policy bits. It gives every lane one of four status codes and turns that code into the per-lane enables that the datapath needs. Those enables are a register-file write, a memory write, a select that forces the written value to all ones, and a flag that marks the element as able to raise a memory exception.

Elements below the start index are left alone. Body elements whose mask bit is set, or all body elements when masking is off, access memory. Masked-off body elements and elements at or past the vector length are governed by their own policy bit. On loads, a set policy bit permits an all-ones fill. The parameter `FILL_ONES` fixes whether the block takes that fill or keeps the element undisturbed. Stores never write or fault on an element that is not active. Results are registered and appear one cycle after the beat.

Top module: `elst_classifier`

## Requirements
- R1: Lane k of a beat carries element index `in_base + k`, computed one bit wider than `in_base` so that it does not wrap. An element whose index is below `in_vstart` gets status code 2'b00 (prestart) and asserts no enable, no fill select and no exception flag.
- R2: An element with `in_vstart <= index < in_vl` whose mask bit `in_mask[k]` is 1, or for which `in_vm` is 1, gets status 2'b01 (active) and sets its exception flag. On a load it sets the register write without fill. On a store (`in_store`=1) it sets the memory write.
- R3: An element with `in_vstart <= index < in_vl`, `in_vm`=0 and `in_mask[k]`=0 gets status 2'b10 (inactive). It never asserts memory write or exception flag.
- R4: An element with index `>= in_vstart` and `>= in_vl` gets status 2'b11 (tail). The prestart rule takes priority over the tail rule.
- R5: A load's inactive element asserts register write together with the fill select only when `in_vma`=1 and `FILL_ONES`=1. Otherwise it asserts neither.
- R6: A load's tail element asserts register write together with the fill select only when `in_vta`=1 and `FILL_ONES`=1. Otherwise it asserts neither.
- R7: On a store, no lane ever asserts register write or fill select, whatever the policy bits are. Only active lanes assert memory write.
- R8: When `in_vm`=1 the mask bits have no effect, and every body element is active.
- R9: When `in_vstart >= in_vl`, no lane of the beat is active, no memory write is issued and no exception flag is set.
- R10: All outputs are registered. A beat presented with `in_valid`=1 at a rising edge appears at the outputs with `out_valid`=1 after that edge. A cycle without `in_valid`, and synchronous reset, drive every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present this cycle |
| in_store | input | 1 | 1 = store, 0 = load |
| in_vm | input | 1 | 1 = masking disabled |
| in_vma | input | 1 | Policy bit for masked-off body elements |
| in_vta | input | 1 | Policy bit for tail elements |
| in_vstart | input | IDXW | First element index to process |
| in_vl | input | IDXW+1 | Vector length |
| in_base | input | IDXW | Index of lane 0 in this beat |
| in_mask | input | LANES | Mask bits, bit k for lane k |
| out_valid | output | 1 | Registered results valid |
| out_status | output | 2*LANES | Status of lane k in bits [2k+1:2k] |
| out_rf_we | output | LANES | Register-file write enable per lane |
| out_mem_we | output | LANES | Memory write enable per lane |
| out_ones_sel | output | LANES | Force written data to all ones per lane |
| out_exc_ok | output | LANES | Lane may raise a memory exception |

## Verification
Every result is due exactly one rising edge after the beat that produced it, and an idle cycle clears the outputs one edge later. The bench applies each beat on a falling edge and compares all lanes on the next falling edge. That point lies half a period after the capturing edge and before the next beat is applied. Two instances are compared side by side, one filling and one keeping elements undisturbed. Expected lane codes and enables come from a small reference model in the bench that works from the rules above.

// File: rtl/elst_pkg.sv
package elst_pkg;

    typedef enum logic [1:0] {
        ES_PRE   = 2'd0,
        ES_ACT   = 2'd1,
        ES_INACT = 2'd2,
        ES_TAIL  = 2'd3
    } elem_status_e;

    typedef struct packed {
        logic rf_we;
        logic mem_we;
        logic ones;
        logic exc;
    } lane_ctl_t;

    // Map a status code and the operation's policy to the lane enables.
    function automatic lane_ctl_t policy_ctl(
        input elem_status_e st,
        input logic         store,
        input logic         vma,
        input logic         vta,
        input logic         fill
    );
        lane_ctl_t c;
        logic      agn;
        c   = '0;
        agn = 1'b0;
        case (st)
            ES_ACT: begin
                c.exc = 1'b1;
                if (store) c.mem_we = 1'b1;
                else       c.rf_we  = 1'b1;
            end
            ES_INACT, ES_TAIL: begin
                agn = (st == ES_INACT) ? vma : vta;
                if (!store && agn && fill) begin
                    c.rf_we = 1'b1;
                    c.ones  = 1'b1;
                end
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/elst_lane_class.sv
module elst_lane_class
    import elst_pkg::*;
#(
    parameter int IDXW = 8,
    localparam int IW  = IDXW + 1
) (
    input  logic [IW-1:0]   idx,
    input  logic [IDXW-1:0] vstart,
    input  logic [IW-1:0]   vl,
    input  logic            vm,
    input  logic            mbit,
    output elem_status_e    st
);
    logic [IW-1:0] vstart_w;
    assign vstart_w = {1'b0, vstart};

    always_comb begin
        if (idx < vstart_w)   st = ES_PRE;
        else if (idx >= vl)   st = ES_TAIL;
        else if (vm || mbit)  st = ES_ACT;
        else                  st = ES_INACT;
    end
endmodule

// File: rtl/elst_lane_act.sv
module elst_lane_act
    import elst_pkg::*;
#(
    parameter bit FILL_ONES = 1'b1
) (
    input  elem_status_e st,
    input  logic         store,
    input  logic         vma,
    input  logic         vta,
    output lane_ctl_t    ctl
);
    always_comb ctl = policy_ctl(st, store, vma, vta, FILL_ONES);
endmodule

// File: rtl/elst_classifier.sv
module elst_classifier
    import elst_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int IDXW      = 8,
    parameter bit FILL_ONES = 1'b1,
    localparam int IW       = IDXW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_store,
    input  logic               in_vm,
    input  logic               in_vma,
    input  logic               in_vta,
    input  logic [IDXW-1:0]    in_vstart,
    input  logic [IDXW:0]      in_vl,
    input  logic [IDXW-1:0]    in_base,
    input  logic [LANES-1:0]   in_mask,
    output logic               out_valid,
    output logic [2*LANES-1:0] out_status,
    output logic [LANES-1:0]   out_rf_we,
    output logic [LANES-1:0]   out_mem_we,
    output logic [LANES-1:0]   out_ones_sel,
    output logic [LANES-1:0]   out_exc_ok
);
    elem_status_e st_d [LANES];
    lane_ctl_t    ctl_d [LANES];
    elem_status_e st_q [LANES];
    lane_ctl_t    ctl_q [LANES];
    logic         valid_q;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [IW-1:0] idx;
        assign idx = {1'b0, in_base} + IW'(k);

        elst_lane_class #(.IDXW(IDXW)) u_class (
            .idx    (idx),
            .vstart (in_vstart),
            .vl     (in_vl),
            .vm     (in_vm),
            .mbit   (in_mask[k]),
            .st     (st_d[k])
        );

        elst_lane_act #(.FILL_ONES(FILL_ONES)) u_act (
            .st    (st_d[k]),
            .store (in_store),
            .vma   (in_vma),
            .vta   (in_vta),
            .ctl   (ctl_d[k])
        );

        always_ff @(posedge clk) begin
            if (rst || !in_valid) begin
                st_q[k]  <= ES_PRE;
                ctl_q[k] <= '0;
            end else begin
                st_q[k]  <= st_d[k];
                ctl_q[k] <= ctl_d[k];
            end
        end

        assign out_status[2*k +: 2] = st_q[k];
        assign out_rf_we[k]         = ctl_q[k].rf_we;
        assign out_mem_we[k]        = ctl_q[k].mem_we;
        assign out_ones_sel[k]      = ctl_q[k].ones;
        assign out_exc_ok[k]        = ctl_q[k].exc;

        // Prestart lanes stay quiet (R1)
        p_prestart_quiet_r1: assert property (@(posedge clk) disable iff (rst)
            (out_valid && st_q[k] == ES_PRE) |->
            !(out_rf_we[k] || out_mem_we[k] || out_ones_sel[k] || out_exc_ok[k]));

        // Exception eligibility only for active lanes (R2, R3)
        p_exc_only_active_r2: assert property (@(posedge clk) disable iff (rst)
            out_exc_ok[k] |-> (st_q[k] == ES_ACT));

        // Memory write only from an active lane (R7)
        p_mem_only_active_r7: assert property (@(posedge clk) disable iff (rst)
            out_mem_we[k] |-> (st_q[k] == ES_ACT));

        // Fill select never without a register write on a non-active lane (R5)
        p_fill_needs_we_r5: assert property (@(posedge clk) disable iff (rst)
            out_ones_sel[k] |-> (out_rf_we[k] && st_q[k] != ES_ACT && st_q[k] != ES_PRE));
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= in_valid;
    end
    assign out_valid = valid_q;

    // Stores never write the register file (R7)
    p_store_no_rf_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_store) |=> (out_rf_we == '0 && out_ones_sel == '0));

    // Empty body issues no access (R9)
    p_empty_body_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ({1'b0, in_vstart} >= in_vl)) |=> (out_mem_we == '0 && out_exc_ok == '0));

    // Idle cycle clears outputs (R10)
    p_idle_clear_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && out_rf_we == '0 && out_mem_we == '0 && out_status == '0));
endmodule

// File: tb/tb_elst_classifier.sv
`timescale 1ns/1ps
module tb_elst_classifier;
    localparam int LANES = 4;
    localparam int IDXW  = 8;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_store, in_vm, in_vma, in_vta;
    logic [IDXW-1:0]  in_vstart, in_base;
    logic [IDXW:0]    in_vl;
    logic [LANES-1:0] in_mask;

    logic               f_valid, u_valid;
    logic [2*LANES-1:0] f_status, u_status;
    logic [LANES-1:0]   f_rf, f_mem, f_ones, f_exc;
    logic [LANES-1:0]   u_rf, u_mem, u_ones, u_exc;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    elst_classifier #(.LANES(LANES), .IDXW(IDXW), .FILL_ONES(1'b1)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_store(in_store),
        .in_vm(in_vm), .in_vma(in_vma), .in_vta(in_vta),
        .in_vstart(in_vstart), .in_vl(in_vl), .in_base(in_base), .in_mask(in_mask),
        .out_valid(f_valid), .out_status(f_status), .out_rf_we(f_rf),
        .out_mem_we(f_mem), .out_ones_sel(f_ones), .out_exc_ok(f_exc));

    elst_classifier #(.LANES(LANES), .IDXW(IDXW), .FILL_ONES(1'b0)) dut_keep (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_store(in_store),
        .in_vm(in_vm), .in_vma(in_vma), .in_vta(in_vta),
        .in_vstart(in_vstart), .in_vl(in_vl), .in_base(in_base), .in_mask(in_mask),
        .out_valid(u_valid), .out_status(u_status), .out_rf_we(u_rf),
        .out_mem_we(u_mem), .out_ones_sel(u_ones), .out_exc_ok(u_exc));

    function automatic logic [1:0] m_status(int idx, int vs, int vl, bit vm, bit mb);
        if (idx < vs)    return 2'd0;
        if (idx >= vl)   return 2'd3;
        if (vm || mb)    return 2'd1;
        return 2'd2;
    endfunction

    task automatic cmp(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare both instances' lanes against the model for the current inputs.
    task automatic check_lanes(string req);
        for (int k = 0; k < LANES; k++) begin
            logic [1:0] s;
            bit rfv, memv, onesv, excv, agn;
            s = m_status(int'(in_base) + k, int'(in_vstart), int'(in_vl), in_vm, in_mask[k]);
            memv  = (s == 2'd1) && in_store;
            excv  = (s == 2'd1);
            agn   = (s == 2'd2) ? in_vma : (s == 2'd3) ? in_vta : 1'b0;
            for (int f = 0; f < 2; f++) begin
                logic [1:0] so;
                bit ro, mo, oo, eo;
                rfv   = !in_store && ((s == 2'd1) || (f == 1 && agn && s != 2'd0));
                onesv = !in_store && f == 1 && agn && (s == 2'd2 || s == 2'd3);
                so = f ? f_status[2*k +: 2] : u_status[2*k +: 2];
                ro = f ? f_rf[k]   : u_rf[k];
                mo = f ? f_mem[k]  : u_mem[k];
                oo = f ? f_ones[k] : u_ones[k];
                eo = f ? f_exc[k]  : u_exc[k];
                cmp(req, $sformatf("fill%0d lane%0d status", f, k), so, s);
                cmp(req, $sformatf("fill%0d lane%0d rf_we", f, k), ro, rfv);
                cmp(req, $sformatf("fill%0d lane%0d mem_we", f, k), mo, memv);
                cmp(req, $sformatf("fill%0d lane%0d ones", f, k), oo, onesv);
                cmp(req, $sformatf("fill%0d lane%0d exc", f, k), eo, excv);
            end
        end
        cmp(req, "out_valid", f_valid, 1);
        cmp(req, "out_valid keep", u_valid, 1);
    endtask

    // Apply one beat on a falling edge; results due after the next rising edge.
    task automatic beat(string req, bit st, bit vm, bit vma, bit vta,
                        int vs, int vl, int base, logic [LANES-1:0] m);
        in_valid  = 1'b1;  in_store = st; in_vm = vm; in_vma = vma; in_vta = vta;
        in_vstart = IDXW'(vs); in_vl = (IDXW+1)'(vl); in_base = IDXW'(base); in_mask = m;
        @(negedge clk);
        check_lanes(req);
    endtask

    task automatic t_reset;
        cmp("R10", "reset valid", f_valid, 0);
        cmp("R10", "reset status", f_status, 0);
        cmp("R10", "reset enables", {f_rf, f_mem, f_ones, f_exc}, 0);
        cmp("R10", "reset keep enables", {u_rf, u_mem, u_ones, u_exc}, 0);
    endtask

    task automatic t_load_mixed;
        // lanes: pre, act, inact, tail
        beat("R1 R2 R3 R4 R5", 0, 0, 1, 0, 1, 3, 0, 4'b0010);
        beat("R5 R6",          0, 0, 0, 1, 1, 3, 0, 4'b0010);
        beat("R5 R6 both",     0, 0, 1, 1, 1, 3, 0, 4'b0000);
    endtask

    task automatic t_store;
        beat("R7", 1, 0, 1, 1, 1, 3, 0, 4'b0010);
        beat("R7 full", 1, 0, 1, 1, 0, 4, 0, 4'b1011);
    endtask

    task automatic t_vm_ignores_mask;
        beat("R8", 0, 1, 1, 1, 0, 200, 8, 4'b0000);
        cmp("R8", "all active rf_we", f_rf, 4'hF);
        cmp("R8", "no fill", f_ones, 0);
        beat("R8 store", 1, 1, 0, 0, 0, 200, 8, 4'b0101);
        cmp("R8", "all active mem_we", f_mem, 4'hF);
    endtask

    task automatic t_empty_body;
        beat("R9", 1, 1, 1, 1, 5, 3, 4, 4'b1111);
        cmp("R9", "no mem", f_mem, 0);
        cmp("R9", "no exc", f_exc, 0);
        beat("R9 load", 0, 0, 1, 1, 6, 6, 4, 4'b1111);
        cmp("R9", "load no exc", f_exc, 0);
    endtask

    task automatic t_wide_index;
        beat("R1 R4 wide", 0, 0, 1, 1, 250, 256, 254, 4'b0011);
        cmp("R4", "tail codes", f_status[7:4], 4'hF);
    endtask

    task automatic t_idle;
        in_valid = 1'b0;
        @(negedge clk);
        cmp("R10", "idle valid", f_valid, 0);
        cmp("R10", "idle enables", {f_rf, f_mem, f_ones, f_exc}, 0);
        cmp("R10", "idle status", f_status, 0);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_store = 1'b0; in_vm = 1'b0;
        in_vma = 1'b0; in_vta = 1'b0; in_vstart = '0; in_vl = '0;
        in_base = '0; in_mask = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_load_mixed();
        t_store();
        t_vm_ignores_mask();
        t_empty_body();
        t_wide_index();
        t_idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule